// File: doc/BRIEF.md
# SDRAM Bank Activation Timing Guard

This block sits between a command scheduler and the command encoder of a four-bank SDRAM controller. The scheduler offers one command per cycle over a valid/ready handshake. The command is an activate, a read, a write or a precharge, and it names a bank. The guard keeps one open flag and one age counter for each bank, plus one device-wide counter of cycles since the last activate. From these it raises `reqReady` only when the offered command breaks none of four rules: the row-to-column delay, the spacing between activates, and the lower and upper limits on how long a row stays open.

The timing limits are set as picosecond values together with the clock period. The block turns each one into a cycle count by dividing and rounding up. If a stalled command stays offered, it is accepted in the first cycle its constraints allow. When a bank has been open long enough to come within a set margin of its maximum open time, the guard raises a per-bank request asking the scheduler to precharge that bank.

Top module: `bank_timing_guard`

## Requirements
- R1: After reset every bank is closed, every `forcePre` bit is 0, and an activate offered to any bank sees `reqReady` high.
- R2: A command is accepted on a rising edge where `reqValid` and `reqReady` are both high. Opcode encoding on `reqOp`: 0 activate, 1 read, 2 write, 3 precharge. An accepted activate to a closed bank sets that bank's `bankOpen` bit from the next cycle. An activate to an open bank is stalled.
- R3: A read or write to an open bank is accepted no earlier than the row-to-column cycle count after that bank's activate. If it is held from the start, it is accepted exactly that many cycles later.
- R4: A read or write to a closed bank is stalled for as long as it is offered.
- R5: Two accepted activates are at least the activate-spacing cycle count apart, even when they go to different banks. A held activate is accepted exactly at that spacing.
- R6: A precharge to an open bank is accepted no earlier than the minimum-open cycle count after its activate. It then clears the bank's `bankOpen` bit from the next cycle.
- R7: A precharge to a closed bank is accepted at once and changes no `bankOpen` bit.
- R8: `forcePre[b]` rises in the cycle in which bank b's age reaches the maximum-open cycle count minus `FORCE_MARGIN`. The age is 1 in the cycle after the activate. The bit stays high until a precharge to bank b is accepted, and it is low from the cycle after that precharge.
- R9: Each cycle count is ceil(time_ps / CLK_PERIOD_PS). With the defaults (4000 ps clock) the values are: row-to-column 18000 ps gives 5, activate spacing 12000 ps gives 3, minimum open 42000 ps gives 11, maximum open 400000 ps gives 100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Scheduler offers a command |
| reqOp | input | 2 | Command opcode (0 act, 1 read, 2 write, 3 precharge) |
| reqBank | input | 2 | Target bank |
| reqReady | output | 1 | Offered command meets all timing rules |
| bankOpen | output | 4 | Per-bank open flag |
| forcePre | output | 4 | Per-bank request to precharge before the maximum open time |

## Verification
A wrong age counter shows up as a read, write or precharge that is accepted one or more cycles away from the expected grant cycle, or as a `forcePre` edge that comes early or late. The bench measures both against the cycle of the activate. A stuck or miscounting activate-spacing counter appears as a shifted grant cycle on the second of two back-to-back activates. A wrong open flag appears in `bankOpen` one cycle after the accepted command, or as a stall that never clears.

// File: rtl/btg_pkg.sv
package btg_pkg;
  localparam int unsigned BANKS  = 4;
  localparam int unsigned BANK_W = $clog2(BANKS);

  typedef enum logic [1:0] {
    OP_ACT   = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_PRE   = 2'd3
  } reqOp_e;

  // strobes from control to datapath, one bit per bank
  typedef struct packed {
    logic [BANKS-1:0] act;
    logic [BANKS-1:0] pre;
  } bankStb_t;

  function automatic int unsigned psToCycles(input int unsigned ps, input int unsigned clkPs);
    return (ps + clkPs - 1) / clkPs;
  endfunction
endpackage

// File: rtl/btg_datapath.sv
module btg_datapath
  import btg_pkg::*;
#(
  parameter int unsigned CNT_W      = 7,
  parameter int unsigned RCD_CYC    = 5,
  parameter int unsigned RRD_CYC    = 3,
  parameter int unsigned RASMIN_CYC = 11,
  parameter int unsigned RASMAX_CYC = 100,
  parameter int unsigned WARN_CYC   = 92
) (
  input  logic             clk,
  input  logic             rstN,
  input  bankStb_t         stb,
  output logic [BANKS-1:0] openQ,
  output logic [BANKS-1:0] rcdOk,
  output logic [BANKS-1:0] rasMinOk,
  output logic [BANKS-1:0] nearMax,
  output logic             rrdOk
);
  localparam int unsigned RRD_W = $clog2(RRD_CYC + 1);

  logic [CNT_W-1:0] age [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rstN) begin
        openQ[b] <= 1'b0;
        age[b]   <= '0;
      end else if (stb.act[b]) begin
        openQ[b] <= 1'b1;
        age[b]   <= CNT_W'(1);
      end else if (stb.pre[b]) begin
        openQ[b] <= 1'b0;
        age[b]   <= '0;
      end else if (openQ[b] && age[b] != CNT_W'(RASMAX_CYC)) begin
        age[b] <= age[b] + CNT_W'(1);
      end
    end

    assign rcdOk[b]    = openQ[b] && (age[b] >= CNT_W'(RCD_CYC));
    assign rasMinOk[b] = openQ[b] && (age[b] >= CNT_W'(RASMIN_CYC));
    assign nearMax[b]  = openQ[b] && (age[b] >= CNT_W'(WARN_CYC));

    p_open_after_act_r2: assert property (@(posedge clk) disable iff (!rstN)
      stb.act[b] |=> openQ[b]);
    p_pre_min_r6: assert property (@(posedge clk) disable iff (!rstN)
      (stb.pre[b] && openQ[b]) |-> (age[b] >= CNT_W'(RASMIN_CYC)));
    p_idle_after_pre_r6: assert property (@(posedge clk) disable iff (!rstN)
      stb.pre[b] |=> !openQ[b]);
    p_force_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
      stb.pre[b] |=> !nearMax[b]);
  end

  logic [RRD_W-1:0] sinceAct;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceAct <= RRD_W'(RRD_CYC);
    end else if (|stb.act) begin
      sinceAct <= RRD_W'(1);
    end else if (sinceAct < RRD_W'(RRD_CYC)) begin
      sinceAct <= sinceAct + RRD_W'(1);
    end
  end

  assign rrdOk = (sinceAct >= RRD_W'(RRD_CYC));

  p_rrd_gap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (|stb.act) |-> (sinceAct >= RRD_W'(RRD_CYC)));
endmodule

// File: rtl/btg_ctrl.sv
module btg_ctrl
  import btg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [BANKS-1:0]  bankOpen,
  input  logic [BANKS-1:0]  rcdOk,
  input  logic [BANKS-1:0]  rasMinOk,
  input  logic              rrdOk,
  output logic              reqReady,
  output bankStb_t          stb
);
  reqOp_e opDec;
  logic   grant;

  assign opDec = reqOp_e'(reqOp);

  always_comb begin
    unique case (opDec)
      OP_ACT:           reqReady = !bankOpen[reqBank] && rrdOk;
      OP_READ, OP_WRITE: reqReady = rcdOk[reqBank];
      OP_PRE:           reqReady = !bankOpen[reqBank] || rasMinOk[reqBank];
      default:          reqReady = 1'b0;
    endcase
  end

  assign grant = reqValid && reqReady;

  always_comb begin
    stb = '0;
    if (grant && opDec == OP_ACT) stb.act[reqBank] = 1'b1;
    if (grant && opDec == OP_PRE && bankOpen[reqBank]) stb.pre[reqBank] = 1'b1;
  end

  p_single_act_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb.act));
  p_act_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    (|stb.act) |=> $countones(bankOpen) == $countones($past(bankOpen)) + 1);
endmodule

// File: rtl/bank_timing_guard.sv
module bank_timing_guard
  import btg_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 4000,
  parameter int unsigned T_RCD_PS      = 18000,
  parameter int unsigned T_RRD_PS      = 12000,
  parameter int unsigned T_RASMIN_PS   = 42000,
  parameter int unsigned T_RASMAX_PS   = 400000,
  parameter int unsigned FORCE_MARGIN  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic [BANK_W-1:0] reqBank,
  output logic              reqReady,
  output logic [BANKS-1:0]  bankOpen,
  output logic [BANKS-1:0]  forcePre
);
  localparam int unsigned RCD_CYC    = psToCycles(T_RCD_PS, CLK_PERIOD_PS);
  localparam int unsigned RRD_CYC    = psToCycles(T_RRD_PS, CLK_PERIOD_PS);
  localparam int unsigned RASMIN_CYC = psToCycles(T_RASMIN_PS, CLK_PERIOD_PS);
  localparam int unsigned RASMAX_CYC = psToCycles(T_RASMAX_PS, CLK_PERIOD_PS);
  localparam int unsigned WARN_CYC   = RASMAX_CYC - FORCE_MARGIN;
  localparam int unsigned CNT_W      = $clog2(RASMAX_CYC + 1);

  bankStb_t         stb;
  logic [BANKS-1:0] rcdOk;
  logic [BANKS-1:0] rasMinOk;
  logic             rrdOk;

  btg_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqOp    (reqOp),
    .reqBank  (reqBank),
    .bankOpen (bankOpen),
    .rcdOk    (rcdOk),
    .rasMinOk (rasMinOk),
    .rrdOk    (rrdOk),
    .reqReady (reqReady),
    .stb      (stb)
  );

  btg_datapath #(
    .CNT_W      (CNT_W),
    .RCD_CYC    (RCD_CYC),
    .RRD_CYC    (RRD_CYC),
    .RASMIN_CYC (RASMIN_CYC),
    .RASMAX_CYC (RASMAX_CYC),
    .WARN_CYC   (WARN_CYC)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .openQ    (bankOpen),
    .rcdOk    (rcdOk),
    .rasMinOk (rasMinOk),
    .nearMax  (forcePre),
    .rrdOk    (rrdOk)
  );
endmodule

// File: tb/tb_bank_timing_guard.sv
`timescale 1ns/1ps
module tb_bank_timing_guard;
  localparam int CLK_PS = 4000;
  localparam int RCD    = (18000 + CLK_PS - 1) / CLK_PS;
  localparam int RRD    = (12000 + CLK_PS - 1) / CLK_PS;
  localparam int RASMIN = (42000 + CLK_PS - 1) / CLK_PS;
  localparam int RASMAX = (400000 + CLK_PS - 1) / CLK_PS;
  localparam int WARN   = RASMAX - 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic [1:0] reqOp = 2'd0;
  logic [1:0] reqBank = 2'd0;
  logic       reqReady;
  logic [3:0] bankOpen;
  logic [3:0] forcePre;

  int vecCnt = 0;
  int badCnt = 0;
  int cycCnt = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cycCnt <= cycCnt + 1;

  bank_timing_guard dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqBank(reqBank),
    .reqReady(reqReady), .bankOpen(bankOpen), .forcePre(forcePre)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vecCnt++;
    if (!ok) begin
      badCnt++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // offer a command and hold it until accepted; returns cycle stamp of the grant
  task automatic doReq(input logic [1:0] op, input logic [1:0] bank, output int gcyc);
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqBank = bank;
    #1;
    while (!reqReady) begin
      @(negedge clk); #1;
    end
    @(posedge clk); #1;
    gcyc = cycCnt;
    reqValid = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    check(bankOpen == 4'b0, "R1 banks closed", int'(bankOpen), 0);
    check(forcePre == 4'b0, "R1 no forcePre", int'(forcePre), 0);
    for (int b = 0; b < 4; b++) begin
      reqOp = 2'd0; reqBank = 2'(b); #1;
      check(reqReady == 1'b1, "R1 act ready", int'(reqReady), 1);
    end
  endtask

  task automatic t_rowcol();
    int gAct, gRd, gWr, gPre;
    doReq(2'd0, 2'd0, gAct);
    check(bankOpen == 4'b0001, "R2 bank0 open", int'(bankOpen), 1);
    doReq(2'd1, 2'd0, gRd);
    check(gRd - gAct == RCD, "R3 read delay (R9 rounding)", gRd - gAct, RCD);
    doReq(2'd2, 2'd0, gWr);
    check(gWr - gRd == 1, "R3 write back-to-back", gWr - gRd, 1);
    @(negedge clk); reqOp = 2'd0; reqBank = 2'd0; #1;
    check(reqReady == 1'b0, "R2 act to open bank stalled", int'(reqReady), 0);
    doReq(2'd3, 2'd0, gPre);
    check(gPre - gAct == RASMIN, "R6 precharge min open", gPre - gAct, RASMIN);
    check(bankOpen == 4'b0, "R6 bank closed after pre", int'(bankOpen), 0);
  endtask

  task automatic t_idle();
    int g;
    @(negedge clk); reqOp = 2'd1; reqBank = 2'd1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); #1;
      check(reqReady == 1'b0, "R4 read to closed bank stalled", int'(reqReady), 0);
    end
    reqOp = 2'd2; #1;
    check(reqReady == 1'b0, "R4 write to closed bank stalled", int'(reqReady), 0);
    doReq(2'd0, 2'd3, g);
    doReq(2'd3, 2'd2, g);
    check(bankOpen == 4'b1000, "R7 idle precharge no effect", int'(bankOpen), 8);
    repeat (RASMIN) @(posedge clk);
    doReq(2'd3, 2'd3, g);
    check(bankOpen == 4'b0, "R7 cleanup", int'(bankOpen), 0);
  endtask

  task automatic t_spacing();
    int g1, g2, g3, g;
    doReq(2'd0, 2'd1, g1);
    doReq(2'd0, 2'd2, g2);
    check(g2 - g1 == RRD, "R5 act spacing 1->2", g2 - g1, RRD);
    doReq(2'd0, 2'd3, g3);
    check(g3 - g2 == RRD, "R5 act spacing 2->3", g3 - g2, RRD);
    check(bankOpen == 4'b1110, "R2 three banks open", int'(bankOpen), 14);
    for (int b = 1; b < 4; b++) doReq(2'd3, 2'(b), g);
    check(bankOpen == 4'b0, "R6 all closed", int'(bankOpen), 0);
  endtask

  task automatic t_force();
    int gAct, gSeen, g;
    doReq(2'd0, 2'd0, gAct);
    while (!forcePre[0]) begin
      @(negedge clk); #1;
    end
    gSeen = cycCnt;
    check(gSeen - gAct == WARN - 1, "R8 forcePre timing", gSeen - gAct, WARN - 1);
    check(forcePre[3:1] == 3'b0, "R8 other banks quiet", int'(forcePre), 1);
    repeat (20) @(posedge clk);
    #1;
    check(forcePre[0] == 1'b1, "R8 forcePre held", int'(forcePre[0]), 1);
    doReq(2'd3, 2'd0, g);
    check(forcePre == 4'b0, "R8 forcePre cleared", int'(forcePre), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    t_reset();
    t_rowcol();
    t_idle();
    t_spacing();
    t_force();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, badCnt);
    $finish;
  end

  initial begin
    #80000;
    if (!done) begin
      vecCnt++;
      badCnt++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, badCnt);
      $finish;
    end
  end
endmodule